// File: doc/BRIEF.md
# Byte-Serial Wide Instruction Fetch Assembler

This block fetches wide instruction words from an instruction memory that is only one byte wide. Each instruction is three bytes. The block reads one byte per clock cycle, so each pipeline stage lasts three cycles. The block drives the byte address at the rising edge of the clock. It captures the returned byte at the falling edge of the same cycle. An external memory therefore has half a cycle to answer. After the third byte arrives, the block presents the completed 24-bit word for one cycle, together with the address of its first byte.

Downstream stages see a 2-bit cycle counter that tells them which of the three cycles is in progress. A stage that resolves a taken branch hands the target to this block during the last cycle of a stage. The block then fetches the next two instructions in sequence; these are the delay slots. It redirects the fetch to the target only after both have been fetched. Byte addresses, including the instruction counter, wrap modulo 256.

Top module: `vliw_byte_fetch`

## Requirements
- R1: While `rst_n` is low, `phase` is 0, `mem_addr` equals the reset start address (default 0) and `instr_valid` is 0. The first instruction fetched after reset starts at that address.
- R2: `phase` counts 0, 1, 2, 0, … and advances once per rising clock edge. It never takes the value 3.
- R3: During each cycle, `mem_addr` equals the current instruction address plus `phase`. The three byte reads of one instruction therefore use consecutive addresses.
- R4: The byte read in phase 0 fills bits 23:16 of `instr_word`, the byte read in phase 1 fills bits 15:8, and the byte read in phase 2 fills bits 7:0.
- R5: `instr_valid` is high for exactly one cycle, in the cycle that follows phase 2. In that cycle `instr_pc` holds the address of the instruction's first byte.
- R6: Without a redirect, each instruction starts 3 byte addresses after the previous one. Instruction addresses and byte addresses wrap modulo 256.
- R7: A `br_req` sampled at the rising edge that ends phase 2 is a taken branch. The next two instructions are fetched in sequence, and the instruction after them starts at `br_target`.
- R8: A `br_req` sampled while `phase` is 0 or 1 is ignored, and sequential fetch continues.
- R9: A `br_req` that arrives while an earlier branch is still waiting out its delay slots is ignored. The earlier target is used.
- R10: `mem_rdata` is sampled at the falling clock edge. Its value during the high half of the clock has no effect on the assembled word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; address launched on rising edge, data captured on falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| br_req | input | 1 | Taken-branch request, sampled at the end of phase 2 |
| br_target | input | 8 | Byte address of the branch target |
| mem_rdata | input | 8 | Byte returned by instruction memory |
| mem_addr | output | 8 | Byte address presented to instruction memory |
| phase | output | 2 | Cycle number within the current three-cycle stage |
| instr_word | output | 24 | Assembled instruction word |
| instr_pc | output | 8 | Address of the first byte of `instr_word` |
| instr_valid | output | 1 | One-cycle strobe marking a new `instr_word` |

## Verification
The hardest situation to reach is a second branch request that lands in the short window before an earlier redirect has taken effect. The bench issues one branch at the end of a stage. It then waits for the very next stage end and issues a second branch with a different target. It checks that the delay slot still follows in sequence and that fetch lands on the first target. The falling-edge capture is exercised by corrupting the memory data only during the high half of each clock while whole instructions are assembled. The wrap case is reached by branching to an address two bytes below the top of memory.

// File: rtl/vliw_byte_fetch.sv
module vliw_byte_fetch #(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter int BYTES = 3,
  parameter int SLOTS = 2,
  parameter logic [AW-1:0] RESET_PC = '0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                br_req,
  input  logic [AW-1:0]       br_target,
  input  logic [DW-1:0]       mem_rdata,
  output logic [AW-1:0]       mem_addr,
  output logic [1:0]          phase,
  output logic [DW*BYTES-1:0] instr_word,
  output logic [AW-1:0]       instr_pc,
  output logic                instr_valid
);
  localparam int WW = DW * BYTES;
  localparam int CW = $clog2(SLOTS + 1);
  localparam logic [1:0] LAST = 2'(BYTES - 1);
  localparam logic [AW-1:0] STEP = AW'(BYTES);
  localparam logic [CW-1:0] ARM = CW'(SLOTS);

  logic [AW-1:0] pc;
  logic [AW-1:0] pend_tgt;
  logic [CW-1:0] pend_cnt;
  logic [WW-1:0] asm_buf;

  assign mem_addr = pc + AW'(phase);

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) asm_buf <= '0;
    else asm_buf[WW-1-int'(phase)*DW -: DW] <= mem_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase       <= '0;
      pc          <= RESET_PC;
      pend_tgt    <= '0;
      pend_cnt    <= '0;
      instr_valid <= 1'b0;
      instr_word  <= '0;
      instr_pc    <= '0;
    end else begin
      instr_valid <= 1'b0;
      if (phase == LAST) begin
        phase       <= '0;
        instr_valid <= 1'b1;
        instr_word  <= asm_buf;
        instr_pc    <= pc;
        if (pend_cnt == CW'(1)) begin
          pc       <= pend_tgt;
          pend_cnt <= '0;
        end else begin
          pc <= pc + STEP;
          if (pend_cnt != '0) pend_cnt <= pend_cnt - CW'(1);
        end
        if (br_req && pend_cnt == '0) begin
          pend_cnt <= ARM;
          pend_tgt <= br_target;
        end
      end else begin
        phase <= phase + 2'd1;
      end
    end
  end

  a_r2_phase_range: assert property (@(posedge clk) disable iff (!rst_n)
    phase <= LAST);
  a_r2_phase_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    phase == LAST |=> phase == 2'd0);
  a_r3_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    phase != LAST |=> mem_addr == $past(mem_addr) + AW'(1));
  a_r5_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    instr_valid |=> !instr_valid);
  a_r5_valid_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    instr_valid |-> $past(phase) == LAST);
  a_r7_slot_bound: assert property (@(posedge clk) disable iff (!rst_n)
    pend_cnt <= ARM);
  a_r8_no_arm_mid_stage: assert property (@(posedge clk) disable iff (!rst_n)
    phase != LAST && pend_cnt == '0 |=> pend_cnt == '0);
endmodule

// File: tb/vliw_byte_fetch_bench.sv
`timescale 1ns/100ps
module vliw_byte_fetch_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic br_req = 1'b0;
  logic [7:0] br_target = '0;
  logic [7:0] mem_rdata, mem_addr, instr_pc;
  logic [1:0] phase;
  logic [23:0] instr_word;
  logic instr_valid;
  logic glitch = 1'b0;
  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  function automatic logic [7:0] mb(input logic [7:0] a);
    return (a ^ 8'hA5) + {a[3:0], a[7:4]};
  endfunction
  function automatic logic [23:0] wexp(input logic [7:0] p);
    return {mb(p), mb(p + 8'd1), mb(p + 8'd2)};
  endfunction

  assign mem_rdata = mb(mem_addr) ^ (glitch ? 8'hFF : 8'h00);

  vliw_byte_fetch u_vliw_byte_fetch (
    .clk(clk), .rst_n(rst_n), .br_req(br_req), .br_target(br_target),
    .mem_rdata(mem_rdata), .mem_addr(mem_addr), .phase(phase),
    .instr_word(instr_word), .instr_pc(instr_pc), .instr_valid(instr_valid)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_valid();
    do @(negedge clk); while (!instr_valid);
  endtask

  task automatic expect_instr(input logic [7:0] p, input string tag);
    wait_valid();
    chk(instr_pc == p, {tag, " pc"}, instr_pc, p);
    chk(instr_word == wexp(p), {tag, " word"}, instr_word, wexp(p));
  endtask

  task automatic issue_branch(input logic [7:0] tgt, output logic [7:0] p);
    do @(negedge clk); while (phase != 2'd2);
    br_req = 1'b1;
    br_target = tgt;
    @(negedge clk);
    br_req = 1'b0;
    p = instr_pc;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(phase == 2'd0, "R1 reset phase", phase, 0);
    chk(mem_addr == 8'd0, "R1 reset addr", mem_addr, 0);
    chk(instr_valid == 1'b0, "R1 reset valid", instr_valid, 0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_sequence();
    logic [7:0] a0;
    chk(phase == 2'd0, "R2 phase0", phase, 0);
    a0 = mem_addr;
    for (int k = 1; k < 3; k++) begin
      @(negedge clk);
      chk(phase == 2'(k), "R2 phase step", phase, k);
      chk(mem_addr == a0 + 8'(k), "R3 byte addr", mem_addr, a0 + 8'(k));
    end
    @(negedge clk);
    chk(instr_valid == 1'b1, "R5 valid after phase2", instr_valid, 1);
    chk(instr_pc == 8'd0, "R1 first pc", instr_pc, 0);
    chk(instr_word == wexp(8'd0), "R4 byte order", instr_word, wexp(8'd0));
    chk(phase == 2'd0, "R2 wrap to 0", phase, 0);
    @(negedge clk);
    chk(instr_valid == 1'b0, "R5 one-cycle strobe", instr_valid, 0);
    expect_instr(8'd3, "R6 step3");
    expect_instr(8'd6, "R6 step6");
  endtask

  task automatic t_branch_wrap();
    logic [7:0] p;
    issue_branch(8'd254, p);
    expect_instr(p + 8'd3, "R7 slot1");
    expect_instr(p + 8'd6, "R7 slot2");
    expect_instr(8'd254, "R7 target");
    expect_instr(8'd1, "R6 wrap");
  endtask

  task automatic t_offphase();
    logic [7:0] p;
    do @(negedge clk); while (phase != 2'd0);
    br_req = 1'b1;
    br_target = 8'h80;
    @(negedge clk);
    br_target = 8'h90;
    @(negedge clk);
    br_req = 1'b0;
    wait_valid();
    p = instr_pc;
    for (int k = 1; k <= 4; k++)
      expect_instr(p + 8'(3 * k), "R8 ignored off-phase");
  endtask

  task automatic t_nested();
    logic [7:0] p, q;
    issue_branch(8'h40, p);
    issue_branch(8'hC0, q);
    chk(q == p + 8'd3, "R9 slot1", q, p + 8'd3);
    expect_instr(p + 8'd6, "R9 slot2");
    expect_instr(8'h40, "R9 first target");
    expect_instr(8'h43, "R9 no second redirect");
  endtask

  task automatic t_glitch();
    logic [7:0] p;
    wait_valid();
    p = instr_pc;
    fork
      begin
        repeat (9) begin
          @(posedge clk);
          #0.5 glitch = 1'b1;
          #1.5 glitch = 1'b0;
        end
      end
      begin
        expect_instr(p + 8'd3, "R10 high-half data ignored");
        expect_instr(p + 8'd6, "R10 high-half data ignored");
      end
    join
  endtask

  initial begin
    t_reset();
    t_sequence();
    t_branch_wrap();
    t_offphase();
    t_nested();
    t_glitch();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule